// File: doc/BRIEF.md
# Descriptor DMA Channel Register Interface

This block is the register front end of a multi-channel descriptor DMA engine. A 4 KB window is reached over a plain 32-bit read/write bus. The window is cut into 32 equal slices of 128 bytes, one per channel. The upper address bits pick the channel and the word offset inside the slice picks one of the channel's registers. The registers are little-endian 32-bit words: a command pointer pair, interrupt, branch and wait condition selects, a transfer mode, a second data pointer pair and two address-extension words.

Each channel also holds a 16-bit status word. Software never writes the status word directly. It changes it through the control register, which acts as a masked set/clear port: the upper half of the written word chooses which status bits may change, and the lower half gives their new values. The six sequencing flags of every channel (run, pause, flush, wake, dead, active) are brought out as per-channel vectors. A one-cycle start pulse tells the sequencer when software has asked an idle channel to run. While a channel is active, the low command pointer word is write-protected, so a descriptor walk in progress cannot be redirected.

Descriptor fetch and data movement sit outside this block. It only stores, protects and presents the channel state.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register in every channel reads zero, and all flag and start outputs are zero.
- R2: The channel is byte address bits 11:7 and the register index is bits 6:2. A write changes only the addressed register of the addressed channel.
- R3: Indices 2 to 9, 0xB and 0xC store a full 32-bit word and read it back. Read data and a valid strobe are presented exactly one cycle after the read request, and the valid strobe is low in every cycle that does not follow a request.
- R4: A write to index 0 (control) sets status bit n to data bit n wherever data bit n+16 is 1, and leaves every other status bit unchanged. Index 0 reads as zero.
- R5: Index 1 (status) reads the 16 status bits in bits 15:0 with bits 31:16 zero. A bus write to index 1 leaves the status unchanged.
- R6: A write to index 3 (command pointer low) is dropped while status bit 10 (active) of that channel is 1. Index 2 stays writable.
- R7: Indices 0xA, 0xD, 0xE, 0xF and 0x10 to 0x1F read zero and ignore writes.
- R8: Per-channel output vectors show status bit 15 (run), 14 (pause), 13 (flush), 12 (wake), 11 (dead) and 10 (active), updated one cycle after the control write.
- R9: A control write that sets run (mask bit 31 and data bit 15 both 1) while that channel's active bit is 0 raises the channel's start output for exactly one cycle, in the cycle after the write. No pulse occurs when active is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWordAddr | input | 10 | Word address within the window (byte address bits 11:2) |
| busWrEn | input | 1 | Write request for this cycle |
| busRdEn | input | 1 | Read request for this cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the request |
| busRdValid | output | 1 | Marks busRdData as valid |
| chanRun | output | 32 | Run flag per channel |
| chanPause | output | 32 | Pause flag per channel |
| chanFlush | output | 32 | Flush flag per channel |
| chanWake | output | 32 | Wake flag per channel |
| chanDead | output | 32 | Dead flag per channel |
| chanActive | output | 32 | Active flag per channel |
| chanStart | output | 32 | One-cycle start pulse per channel |

## Verification
Every result is due one clock edge after its stimulus. Read data and its valid strobe register at the edge that samples the request. Status, the flag vectors and the start pulse change at the edge that samples the control write. The bench drives each request at a falling edge and samples at the next falling edge, which is exactly one rising edge later. For the start pulse it samples again one falling edge after that, to confirm that the pulse has already gone away. Write protection is checked by reading the protected word back after the dropped write, and again after active has been cleared.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // Register indices whose position is decoded by the datapath
  localparam int REG_CTRL   = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_CPHI   = 2;
  localparam int REG_CPLO   = 3;

  // Status bit positions exported to the sequencer
  localparam int ST_RUN    = 15;
  localparam int ST_PAUSE  = 14;
  localparam int ST_FLUSH  = 13;
  localparam int ST_WAKE   = 12;
  localparam int ST_DEAD   = 11;
  localparam int ST_ACTIVE = 10;

  // Backing storage: ten plain words per channel
  localparam int NUM_STORE = 10;
  localparam int SLOT_W    = $clog2(NUM_STORE);

  // Strobes handed from the decode to the datapath
  typedef struct packed {
    logic ctrlWr;   // masked set/clear of status
    logic storeWr;  // plain word write, already filtered
    logic rdReq;    // capture read data this cycle
  } reg_strb_t;

  function automatic logic isStorable(int unsigned idx);
    return (idx >= 2 && idx <= 9) || idx == 11 || idx == 12;
  endfunction

  function automatic logic [SLOT_W-1:0] slotOf(int unsigned idx);
    if (idx >= 2 && idx <= 9) return SLOT_W'(idx - 2);
    if (idx == 11) return SLOT_W'(8);
    if (idx == 12) return SLOT_W'(9);
    return '0;
  endfunction

endpackage

// File: rtl/dma_regs_ctrl.sv
module dma_regs_ctrl
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CHAN_SHIFT = 7,
  localparam int CHAN_W    = ADDR_W - CHAN_SHIFT,
  localparam int IDX_W     = CHAN_SHIFT - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:2] busWordAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              selActive,
  output logic [CHAN_W-1:0] chanSel,
  output logic [IDX_W-1:0]  regIdx,
  output reg_strb_t         strb,
  output logic              rdValid
);

  logic cpLoHit;
  logic cpLoLocked;

  assign chanSel = busWordAddr[ADDR_W-1:CHAN_SHIFT];
  assign regIdx  = busWordAddr[CHAN_SHIFT-1:2];

  assign cpLoHit    = (regIdx == IDX_W'(REG_CPLO));
  assign cpLoLocked = cpLoHit && selActive;

  always_comb begin
    strb         = '0;
    strb.ctrlWr  = busWrEn && (regIdx == IDX_W'(REG_CTRL));
    strb.storeWr = busWrEn && isStorable(32'(regIdx)) && !cpLoLocked;
    strb.rdReq   = busRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busRdEn;
  end

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> rdValid);

  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !rdValid);

endmodule

// File: rtl/dma_regs_data.sv
module dma_regs_data
  import dma_regs_pkg::*;
#(
  parameter int CHAN_W    = 5,
  parameter int IDX_W     = 5,
  parameter int DATA_W    = 32,
  localparam int NUM_CHAN = 1 << CHAN_W,
  localparam int STAT_W   = DATA_W / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  reg_strb_t           strb,
  input  logic [CHAN_W-1:0]   chanSel,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                selActive,
  output logic [NUM_CHAN-1:0] runVec,
  output logic [NUM_CHAN-1:0] pauseVec,
  output logic [NUM_CHAN-1:0] flushVec,
  output logic [NUM_CHAN-1:0] wakeVec,
  output logic [NUM_CHAN-1:0] deadVec,
  output logic [NUM_CHAN-1:0] activeVec,
  output logic [NUM_CHAN-1:0] startVec
);

  localparam int SLOT_CPLO = REG_CPLO - 2;

  logic [STAT_W-1:0] ctrlMask;
  logic [STAT_W-1:0] ctrlVal;
  logic [SLOT_W-1:0] wrSlot;
  logic [DATA_W-1:0] rdMux;

  logic [STAT_W-1:0] statAll  [NUM_CHAN];
  logic [DATA_W-1:0] storeAll [NUM_CHAN][NUM_STORE];

  assign ctrlMask = wrData[DATA_W-1:STAT_W];
  assign ctrlVal  = wrData[STAT_W-1:0];
  assign wrSlot   = slotOf(32'(regIdx));

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [DATA_W-1:0] slotQ [NUM_STORE];
    logic [STAT_W-1:0] statQ;
    logic              startQ;
    logic              hit;

    assign hit = (chanSel == CHAN_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statQ  <= '0;
        startQ <= 1'b0;
        for (int s = 0; s < NUM_STORE; s++) slotQ[s] <= '0;
      end else begin
        startQ <= hit && strb.ctrlWr && ctrlMask[ST_RUN] && ctrlVal[ST_RUN]
                  && !statQ[ST_ACTIVE];
        if (hit && strb.ctrlWr)
          statQ <= (statQ & ~ctrlMask) | (ctrlVal & ctrlMask);
        if (hit && strb.storeWr)
          slotQ[wrSlot] <= wrData;
      end
    end

    assign statAll[c]   = statQ;
    assign storeAll[c]  = slotQ;
    assign runVec[c]    = statQ[ST_RUN];
    assign pauseVec[c]  = statQ[ST_PAUSE];
    assign flushVec[c]  = statQ[ST_FLUSH];
    assign wakeVec[c]   = statQ[ST_WAKE];
    assign deadVec[c]   = statQ[ST_DEAD];
    assign activeVec[c] = statQ[ST_ACTIVE];
    assign startVec[c]  = startQ;

    // R6
    cmdlo_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
      statQ[ST_ACTIVE] |=> $stable(slotQ[SLOT_CPLO]));

    // R9
    start_needs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      startQ |-> (statQ[ST_RUN] && !$past(statQ[ST_ACTIVE])));
  end

  assign selActive = statAll[chanSel][ST_ACTIVE];

  always_comb begin
    rdMux = '0;
    if (regIdx == IDX_W'(REG_STATUS))
      rdMux = {{(DATA_W-STAT_W){1'b0}}, statAll[chanSel]};
    else if (isStorable(32'(regIdx)))
      rdMux = storeAll[chanSel][wrSlot];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdReq ? rdMux : '0;
  end

  // R4
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && regIdx == IDX_W'(REG_CTRL)) |=> (rdData == '0));

  // R5
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && regIdx == IDX_W'(REG_STATUS)) |=> (rdData[DATA_W-1:STAT_W] == '0));

  // R7
  reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && regIdx > IDX_W'(1) && !isStorable(32'(regIdx))) |=> (rdData == '0));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CHAN_SHIFT = 7,
  parameter int DATA_W     = 32,
  localparam int CHAN_W    = ADDR_W - CHAN_SHIFT,
  localparam int IDX_W     = CHAN_SHIFT - 2,
  localparam int NUM_CHAN  = 1 << CHAN_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:2]   busWordAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  output logic                busRdValid,
  output logic [NUM_CHAN-1:0] chanRun,
  output logic [NUM_CHAN-1:0] chanPause,
  output logic [NUM_CHAN-1:0] chanFlush,
  output logic [NUM_CHAN-1:0] chanWake,
  output logic [NUM_CHAN-1:0] chanDead,
  output logic [NUM_CHAN-1:0] chanActive,
  output logic [NUM_CHAN-1:0] chanStart
);

  logic [CHAN_W-1:0] chanSel;
  logic [IDX_W-1:0]  regIdx;
  reg_strb_t         strb;
  logic              selActive;

  dma_regs_ctrl #(
    .ADDR_W     (ADDR_W),
    .CHAN_SHIFT (CHAN_SHIFT)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .busWordAddr (busWordAddr),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .selActive   (selActive),
    .chanSel     (chanSel),
    .regIdx      (regIdx),
    .strb        (strb),
    .rdValid     (busRdValid)
  );

  dma_regs_data #(
    .CHAN_W (CHAN_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .chanSel   (chanSel),
    .regIdx    (regIdx),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .selActive (selActive),
    .runVec    (chanRun),
    .pauseVec  (chanPause),
    .flushVec  (chanFlush),
    .wakeVec   (chanWake),
    .deadVec   (chanDead),
    .activeVec (chanActive),
    .startVec  (chanStart)
  );

endmodule

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:2] busWordAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic [31:0] chanRun, chanPause, chanFlush, chanWake, chanDead, chanActive, chanStart;

  int total = 0;
  int bad = 0;
  logic [31:0] lastStart;
  logic [31:0] rdVal;
  logic        rdOk;

  always #10 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rstN(rstN), .busWordAddr(busWordAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .chanRun(chanRun), .chanPause(chanPause),
    .chanFlush(chanFlush), .chanWake(chanWake), .chanDead(chanDead),
    .chanActive(chanActive), .chanStart(chanStart)
  );

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'h008, 32'h11112222, 32'h0, 8'd3},
    '{1'b1, 12'h00C, 32'h33334444, 32'h0, 8'd3},
    '{1'b0, 12'h008, 32'h0, 32'h11112222, 8'd3},   // R3
    '{1'b0, 12'h00C, 32'h0, 32'h33334444, 8'd3},   // R3
    '{1'b1, 12'h09C, 32'hA5A5A5A5, 32'h0, 8'd3},
    '{1'b0, 12'h09C, 32'h0, 32'hA5A5A5A5, 8'd3},   // R3
    '{1'b0, 12'h01C, 32'h0, 32'h0, 8'd2},          // R2 other channel untouched
    '{1'b1, 12'hFB0, 32'hDEADBEEF, 32'h0, 8'd2},
    '{1'b0, 12'hFB0, 32'h0, 32'hDEADBEEF, 8'd2},   // R2 top channel
    '{1'b0, 12'h030, 32'h0, 32'h0, 8'd2},          // R2
    '{1'b1, 12'h028, 32'hFFFFFFFF, 32'h0, 8'd7},
    '{1'b0, 12'h028, 32'h0, 32'h0, 8'd7},          // R7
    '{1'b1, 12'h040, 32'h00001234, 32'h0, 8'd7},
    '{1'b0, 12'h040, 32'h0, 32'h0, 8'd7},          // R7
    '{1'b1, 12'h03C, 32'hFFFFFFFF, 32'h0, 8'd7},
    '{1'b0, 12'h03C, 32'h0, 32'h0, 8'd7},          // R7
    '{1'b1, 12'h000, 32'h00FF00A5, 32'h0, 8'd4},
    '{1'b0, 12'h004, 32'h0, 32'h000000A5, 8'd4},   // R4
    '{1'b0, 12'h000, 32'h0, 32'h0, 8'd4},          // R4
    '{1'b1, 12'h004, 32'hFFFFFFFF, 32'h0, 8'd5},
    '{1'b0, 12'h004, 32'h0, 32'h000000A5, 8'd5},   // R5
    '{1'b1, 12'h000, 32'h000F0000, 32'h0, 8'd4},
    '{1'b0, 12'h004, 32'h0, 32'h000000A0, 8'd4},   // R4
    '{1'b1, 12'h020, 32'h0BADF00D, 32'h0, 8'd3},
    '{1'b0, 12'h020, 32'h0, 32'h0BADF00D, 8'd3}    // R3
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic doWrite(logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    busWordAddr = addr[11:2];
    busWrData   = data;
    busWrEn     = 1'b1;
    @(negedge clk);
    lastStart = chanStart;
    busWrEn   = 1'b0;
  endtask

  task automatic doRead(logic [11:0] addr);
    @(negedge clk);
    busWordAddr = addr[11:2];
    busRdEn     = 1'b1;
    @(negedge clk);
    rdVal   = busRdData;
    rdOk    = busRdValid;
    busRdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 run", chanRun, 32'h0);
    chk("R1 active", chanActive, 32'h0);
    chk("R1 start", chanStart, 32'h0);
    chk("R1 rdvalid", {31'b0, busRdValid}, 32'h0);
    doRead(12'h004);
    chk("R1 status", rdVal, 32'h0);
    doRead(12'h288);
    chk("R1 cmdhi ch5", rdVal, 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) doWrite(VECS[i].addr, VECS[i].data);
      else begin
        doRead(VECS[i].addr);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), rdVal, VECS[i].expv);
        chk("R3 valid", {31'b0, rdOk}, 32'h1);
      end
    end
    @(negedge clk);
    chk("R3 valid drops", {31'b0, busRdValid}, 32'h0);

    // R9 / R8: start idle channel 3
    doWrite(12'h180, 32'h80008000);
    chk("R9 start pulse", lastStart, 32'h00000008);
    chk("R8 run vec", chanRun, 32'h00000008);
    @(negedge clk);
    chk("R9 pulse one cycle", chanStart, 32'h0);

    // R8 set active, then R9 no pulse while active
    doWrite(12'h180, 32'h04000400);
    chk("R8 active vec", chanActive, 32'h00000008);
    doWrite(12'h180, 32'h80008000);
    chk("R9 no pulse when active", lastStart, 32'h0);

    // R6 command pointer low locked while active
    doWrite(12'h18C, 32'hCAFE0000);
    doRead(12'h18C);
    chk("R6 cmdlo dropped", rdVal, 32'h0);
    doWrite(12'h188, 32'h00000055);
    doRead(12'h188);
    chk("R6 cmdhi writable", rdVal, 32'h00000055);
    doWrite(12'h180, 32'h04000000);
    chk("R8 active cleared", chanActive, 32'h0);
    doWrite(12'h18C, 32'hCAFE0000);
    doRead(12'h18C);
    chk("R6 cmdlo after idle", rdVal, 32'hCAFE0000);

    // R8 remaining flags on channel 3
    doWrite(12'h180, 32'h78007800);
    chk("R8 pause", chanPause, 32'h00000008);
    chk("R8 flush", chanFlush, 32'h00000008);
    chk("R8 wake", chanWake, 32'h00000008);
    chk("R8 dead", chanDead, 32'h00000008);
    doRead(12'h184);
    chk("R4 status ch3", rdVal, 32'h0000F800);

    // R1 reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 run after reset", chanRun, 32'h0);
    chk("R1 dead after reset", chanDead, 32'h0);
    doRead(12'h008);
    chk("R1 cmdhi after reset", rdVal, 32'h0);
    doRead(12'h18C);
    chk("R1 cmdlo after reset", rdVal, 32'h0);

    finishRun();
  end

endmodule